// File: doc/BRIEF.md
# I2C Transfer Event Interrupt Unit

This block sits next to a simple I2C master/slave byte engine. It watches the bus lines, which it synchronizes itself, and tracks each transaction from its start condition. The tracking covers the address byte, the data bytes and the ending. Six kinds of event raise sticky flags:

- the own slave address was matched;
- a stop condition ended a matched slave transfer;
- a slave transfer ran past its expected size;
- a transfer ended before its expected size;
- a master lost arbitration while transmitting;
- a master's address byte was not acknowledged.

A mask register gates the flags onto one level-sensitive interrupt line.

Software programs the own 7-bit address and an expected data-byte count before a transfer. After an address-match interrupt it reads the captured read/write bit to choose the data-phase direction. Each flag is cleared by writing a 1 to its bit. The engine tells the block whether the next transaction is a master one, and whether it is currently driving a bit. The engine also gives the level it intends to put on SDA. In return, the block tells the engine when to release the bus after lost arbitration, and when to issue a stop after an unacknowledged address.

Top module: `i2c_xfer_event_irq`

## Requirements
- R1: SCL and SDA pass through a two-flop synchronizer. A start is SDA falling while SCL stays high, and a stop is SDA rising while SCL stays high. SDA changes while SCL is low are data and are not treated as conditions.
- R2: In a slave transaction (mst_active low at the start), status bit 0 is set when the address byte (7 address bits, MSB first, then the read/write bit) equals the own address register (address 2, bits 6:0). The read/write bit is captured into bit 0 of register address 4.
- R3: Status bit 1 is set when a stop ends a slave transaction whose address matched. A stop after an unmatched address does not set it, and neither does a repeated start.
- R4: Status bit 2 is set in a matched slave transaction when a data byte completes while the count of earlier data bytes already equals the expected size (register address 3). It is never set in a master transaction.
- R5: Status bit 3 is set when a stop or a repeated start ends a data phase (after a matched slave address or an acknowledged master address) with fewer data bytes than the expected size.
- R6: In a master transaction, when mst_tx is high during one of the 8 bits of a byte and mst_sda_drv is 1 but SDA is sampled 0 at SCL rising, status bit 4 is set. In that case arb_lost goes high and stays high until the next stop or start. With mst_tx low, no loss is detected.
- R7: In a master transaction, an address byte whose ninth bit samples high sets status bit 5 and gives a one-cycle nack_stop_req pulse. Further bytes in that transaction are not counted and cause no early or oversize event.
- R8: irq is high while any flag is set whose bit is set in the enable register (address 1, bits 5:0). The enable register does not change the flags.
- R9: Writing register address 0 clears each flag whose data bit is 1 and leaves the other flags unchanged. A flag is sticky otherwise, and an event in the same cycle as a clear wins.
- R10: The data-byte count is reset at every start (including a repeated start). A byte is counted on the SCL rise of its ninth bit. The address byte is not counted.
- R11: After reset, all flags, the enable, own-address, size and captured read/write registers are 0, and irq, arb_lost and nack_stop_req are low. A read returns its data one cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| mst_active | input | 1 | Engine will run the next transaction as master; sampled at each start |
| mst_tx | input | 1 | Engine is driving the current bit as a master transmitter |
| mst_sda_drv | input | 1 | Level the engine intends on SDA for the current bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid one cycle after reg_rd |
| irq | output | 1 | Level interrupt: any enabled flag set |
| arb_lost | output | 1 | Arbitration lost; engine must stop driving the bus |
| nack_stop_req | output | 1 | One-cycle request to end the transaction with a stop |

## Verification
The bench ends transfers one byte short of, exactly at, and one byte past the expected size, in both slave and master mode. A design that compares at the wrong boundary, or that flags oversize as a master, shows extra or missing status bits. A repeated start into a second transfer to the own address checks that the count restarts: a design that kept counting would report an oversize. After an unacknowledged master address, extra bytes and a premature stop must not set the early flag. A master that receives with SDA low must not report lost arbitration, which catches a checker that ignores the transmit qualifier. The bench also sets, masks, unmasks and clears flags one at a time, which exposes a mask that gates the flag instead of the line, and a clear that touches the wrong bits.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int EV_N      = 6;
  localparam int EV_SADDR  = 0;
  localparam int EV_SSTOP  = 1;
  localparam int EV_OVS    = 2;
  localparam int EV_EARLY  = 3;
  localparam int EV_MLOSS  = 4;
  localparam int EV_NACK   = 5;

  localparam int BYTE_BITS = 8;
  localparam int ADDR_BITS = BYTE_BITS - 1;

  localparam int RA_STATUS = 0;
  localparam int RA_ENABLE = 1;
  localparam int RA_OWN    = 2;
  localparam int RA_SIZE   = 3;
  localparam int RA_RW     = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_DEAD
  } phase_t;
endpackage

// File: rtl/i2c_evt_busmon.sv
module i2c_evt_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det,
  output logic sda_q
);
  logic [SYNC_STAGES-1:0] scl_sync;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic scl_now, sda_now, scl_prev, sda_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sync <= 1'b1;
          sda_sync <= 1'b1;
        end else begin
          scl_sync <= scl_in;
          sda_sync <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
          sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_now = scl_sync[SYNC_STAGES-1];
  assign sda_now = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev  <= 1'b1;
      sda_prev  <= 1'b1;
      scl_rise  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      sda_q     <= 1'b1;
    end else begin
      scl_prev  <= scl_now;
      sda_prev  <= sda_now;
      scl_rise  <= !scl_prev && scl_now;
      start_det <= scl_prev && scl_now && sda_prev && !sda_now;
      stop_det  <= scl_prev && scl_now && !sda_prev && sda_now;
      sda_q     <= sda_now;
    end
  end

  // R1: a bus condition never coincides with a clock edge or its opposite
  p_cond_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    start_det |-> (!stop_det && !scl_rise));
  p_start_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !start_det);
endmodule

// File: rtl/i2c_evt_arb.sv
module i2c_evt_arb (
  input  logic clk,
  input  logic rst,
  input  logic scl_rise,
  input  logic sda_q,
  input  logic start_det,
  input  logic stop_det,
  input  logic tx_window,
  input  logic mst_tx,
  input  logic mst_sda_drv,
  output logic loss_ev,
  output logic arb_lost
);
  logic mismatch;
  assign mismatch = scl_rise && tx_window && mst_tx && mst_sda_drv && !sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      loss_ev  <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      loss_ev <= mismatch;
      if (start_det || stop_det) arb_lost <= 1'b0;
      else if (mismatch)         arb_lost <= 1'b1;
    end
  end

  // R6: the release signal drops after a stop
  p_release_on_stop_r6: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !arb_lost);
  // R6: receive bits never produce a loss
  p_rx_no_loss_r6: assert property (@(posedge clk) disable iff (rst)
    !mst_tx |=> !loss_ev);
endmodule

// File: rtl/i2c_evt_tracker.sv
module i2c_evt_tracker
  import i2c_evt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic                 scl_rise,
  input  logic                 sda_q,
  input  logic                 loss_ev,
  input  logic                 mst_active,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic [CNT_W-1:0]     xfer_len,
  output logic [EV_N-1:0]      ev,
  output logic                 rw_capt,
  output logic                 nack_stop_req,
  output logic                 tx_window
);
  localparam int IDX_W = $clog2(BYTE_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  phase_t               phase;
  logic                 mode_mst;
  logic [IDX_W-1:0]     bit_idx;
  logic [BYTE_BITS-1:0] shreg;
  logic [CNT_W-1:0]     cnt;
  logic                 short_xfer;
  logic                 in_byte;

  assign short_xfer = (phase == PH_DATA) && (cnt < xfer_len);
  assign in_byte    = (phase == PH_ADDR) || (phase == PH_DATA);
  assign tx_window  = mode_mst && in_byte && (bit_idx != LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_IDLE;
      mode_mst      <= 1'b0;
      bit_idx       <= '0;
      shreg         <= '0;
      cnt           <= '0;
      ev            <= '0;
      rw_capt       <= 1'b0;
      nack_stop_req <= 1'b0;
    end else begin
      ev                <= '0;
      nack_stop_req     <= 1'b0;
      ev[EV_MLOSS]      <= loss_ev;
      if (start_det) begin
        if (short_xfer) ev[EV_EARLY] <= 1'b1;
        phase    <= PH_ADDR;
        mode_mst <= mst_active;
        bit_idx  <= '0;
        cnt      <= '0;
      end else if (stop_det) begin
        if (short_xfer) ev[EV_EARLY] <= 1'b1;
        if (phase == PH_DATA && !mode_mst) ev[EV_SSTOP] <= 1'b1;
        phase   <= PH_IDLE;
        bit_idx <= '0;
      end else if (loss_ev) begin
        phase <= PH_DEAD;
      end else if (scl_rise && in_byte) begin
        if (bit_idx != LAST_IDX) begin
          shreg   <= {shreg[BYTE_BITS-2:0], sda_q};
          bit_idx <= bit_idx + 1'b1;
        end else begin
          bit_idx <= '0;
          if (phase == PH_ADDR) begin
            if (mode_mst) begin
              if (sda_q) begin
                ev[EV_NACK]   <= 1'b1;
                nack_stop_req <= 1'b1;
                phase         <= PH_DEAD;
              end else begin
                phase <= PH_DATA;
              end
            end else if (shreg[BYTE_BITS-1:1] == own_addr) begin
              ev[EV_SADDR] <= 1'b1;
              rw_capt      <= shreg[0];
              phase        <= PH_DATA;
            end else begin
              phase <= PH_DEAD;
            end
          end else begin
            if (!mode_mst && cnt == xfer_len) ev[EV_OVS] <= 1'b1;
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R7: an abandoned transaction reports no size or stop events
  p_dead_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DEAD) |=> (!ev[EV_EARLY] && !ev[EV_OVS] && !ev[EV_SSTOP]));
  // R10: the bit position never passes the acknowledge slot
  p_bit_range_r10: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= LAST_IDX);
  // R4: oversize only follows a slave-mode transaction
  p_ovs_slave_r4: assert property (@(posedge clk) disable iff (rst)
    ev[EV_OVS] |-> !mode_mst);
endmodule

// File: rtl/i2c_evt_regs.sv
module i2c_evt_regs
  import i2c_evt_pkg::*;
#(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  input  logic [EV_N-1:0]      ev,
  input  logic                 rw_capt,
  output logic [EV_N-1:0]      flags_q,
  output logic [ADDR_BITS-1:0] own_addr,
  output logic [CNT_W-1:0]     xfer_len,
  output logic [DW-1:0]        reg_rdata,
  output logic                 irq
);
  logic [EV_N-1:0] enable_q;
  logic            wr_status;
  logic [EV_N-1:0] clr_mask;

  assign wr_status = reg_wr && (reg_addr == AW'(RA_STATUS));
  assign clr_mask  = wr_status ? reg_wdata[EV_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      enable_q <= '0;
      own_addr <= '0;
      xfer_len <= '0;
      irq      <= 1'b0;
    end else begin
      flags_q <= ev | (flags_q & ~clr_mask);
      irq     <= |(flags_q & enable_q);
      if (reg_wr && reg_addr == AW'(RA_ENABLE)) enable_q <= reg_wdata[EV_N-1:0];
      if (reg_wr && reg_addr == AW'(RA_OWN))    own_addr <= reg_wdata[ADDR_BITS-1:0];
      if (reg_wr && reg_addr == AW'(RA_SIZE))   xfer_len <= CNT_W'(reg_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        AW'(RA_STATUS): reg_rdata <= DW'(flags_q);
        AW'(RA_ENABLE): reg_rdata <= DW'(enable_q);
        AW'(RA_OWN):    reg_rdata <= DW'(own_addr);
        AW'(RA_SIZE):   reg_rdata <= DW'(xfer_len);
        AW'(RA_RW):     reg_rdata <= DW'(rw_capt);
        default:        reg_rdata <= '0;
      endcase
    end
  end

  // R9: without a status write no flag is lost
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_status |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R9: a clear with no competing event empties the written bits
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_status && ev == '0) |=> ((flags_q & $past(reg_wdata[EV_N-1:0])) == '0));
  // R8: a fully masked enable keeps the line low
  p_masked_low_r8: assert property (@(posedge clk) disable iff (rst)
    (enable_q == '0) |=> !irq);
endmodule

// File: rtl/i2c_xfer_event_irq.sv
module i2c_xfer_event_irq
  import i2c_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_AW      = 3,
  parameter int REG_DW      = 8,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              mst_active,
  input  logic              mst_tx,
  input  logic              mst_sda_drv,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq,
  output logic              arb_lost,
  output logic              nack_stop_req
);
  logic scl_rise, start_det, stop_det, sda_q;
  logic loss_ev, tx_window, rw_capt;
  logic [EV_N-1:0]      ev;
  logic [EV_N-1:0]      flags_q;
  logic [ADDR_BITS-1:0] own_addr;
  logic [CNT_W-1:0]     xfer_len;

  i2c_evt_busmon #(.SYNC_STAGES(SYNC_STAGES)) busmon_i (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .start_det(start_det), .stop_det(stop_det), .sda_q(sda_q)
  );

  i2c_evt_arb arb_i (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .sda_q(sda_q),
    .start_det(start_det), .stop_det(stop_det), .tx_window(tx_window),
    .mst_tx(mst_tx), .mst_sda_drv(mst_sda_drv),
    .loss_ev(loss_ev), .arb_lost(arb_lost)
  );

  i2c_evt_tracker #(.CNT_W(CNT_W)) tracker_i (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .sda_q(sda_q), .loss_ev(loss_ev), .mst_active(mst_active),
    .own_addr(own_addr), .xfer_len(xfer_len), .ev(ev), .rw_capt(rw_capt),
    .nack_stop_req(nack_stop_req), .tx_window(tx_window)
  );

  i2c_evt_regs #(.AW(REG_AW), .DW(REG_DW), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ev(ev), .rw_capt(rw_capt), .flags_q(flags_q),
    .own_addr(own_addr), .xfer_len(xfer_len), .reg_rdata(reg_rdata), .irq(irq)
  );

  // R7: the stop request is a single-cycle pulse and lands in the flag
  p_nack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    nack_stop_req |=> !nack_stop_req);
  p_nack_flag_r7: assert property (@(posedge clk) disable iff (rst)
    nack_stop_req |=> flags_q[EV_NACK]);
  // R6: a detected loss reaches the status flag two cycles later
  p_loss_flag_r6: assert property (@(posedge clk) disable iff (rst)
    loss_ev |=> ##1 flags_q[EV_MLOSS]);
endmodule

// File: tb/i2c_xfer_event_irq_tb_top.sv
module i2c_xfer_event_irq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic scl = 1'b1, sda = 1'b1;
  logic mst_active = 1'b0, mst_tx = 1'b0, mst_sda_drv = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, arb_lost, nack_stop_req;

  int total = 0;
  int bad = 0;
  int nack_cnt = 0;
  bit done = 0;
  string tag_q[$];
  logic [7:0] exp_q[$];

  localparam int Q = 5;

  i2c_xfer_event_irq dut_i (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
    .mst_active(mst_active), .mst_tx(mst_tx), .mst_sda_drv(mst_sda_drv),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .arb_lost(arb_lost), .nack_stop_req(nack_stop_req)
  );

  always @(posedge clk) if (!rst && nack_stop_req) nack_cnt <= nack_cnt + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected value per read
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("scoreboard underflow", 8'h00, 8'hFF);
        else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_expect(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    tag_q.push_back(tag);
    exp_q.push_back(e);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    tick(1);
  endtask

  task automatic b_start();
    sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic b_stop();
    sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda = 1'b1; tick(Q + 4);
  endtask

  task automatic b_bit(input logic line, input logic drv);
    sda = line; mst_sda_drv = drv; tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic b_byte(input logic [7:0] v, input logic ack, input logic mtx);
    for (int i = 7; i >= 0; i--) begin
      mst_tx = mtx;
      b_bit(v[i], v[i]);
    end
    mst_tx = 1'b0;
    b_bit(!ack, 1'b1);
  endtask

  task automatic clear_all();
    reg_write(3'd0, 8'h3F);
  endtask

  initial begin
    int n0;
    tick(5);
    rst = 1'b0;
    tick(3);

    // R11 reset state
    check("R11 irq after reset", {7'b0, irq}, 8'h00);
    check("R11 arb_lost after reset", {7'b0, arb_lost}, 8'h00);
    check("R11 nack_stop_req after reset", {7'b0, nack_stop_req}, 8'h00);
    reg_expect(3'd0, 8'h00, "R11 status after reset");
    reg_expect(3'd1, 8'h00, "R11 enable after reset");
    reg_expect(3'd2, 8'h00, "R11 own address after reset");
    reg_expect(3'd3, 8'h00, "R11 size after reset");
    reg_expect(3'd4, 8'h00, "R11 rw after reset");

    reg_write(3'd2, 8'h3A);
    reg_expect(3'd2, 8'h3A, "R2 own address readback");

    // R2 R3: slave write, exact size
    reg_write(3'd3, 8'd2);
    b_start(); b_byte(8'h74, 1, 0); b_byte(8'h11, 1, 0); b_byte(8'h22, 1, 0); b_stop();
    reg_expect(3'd0, 8'h03, "R2 R3 slave write exact size");
    reg_expect(3'd4, 8'h00, "R2 captured rw write");
    clear_all();

    // R2: slave read captures rw=1
    reg_write(3'd3, 8'd1);
    b_start(); b_byte(8'h75, 1, 0); b_byte(8'h5A, 1, 0); b_stop();
    reg_expect(3'd0, 8'h03, "R2 slave read flags");
    reg_expect(3'd4, 8'h01, "R2 captured rw read");
    clear_all();

    // R3: other address, nothing set
    reg_write(3'd3, 8'd2);
    b_start(); b_byte(8'hA0, 1, 0); b_byte(8'h01, 1, 0); b_stop();
    reg_expect(3'd0, 8'h00, "R3 unmatched address no flags");

    // R4: slave oversize
    b_start(); b_byte(8'h74, 1, 0);
    b_byte(8'h01, 1, 0); b_byte(8'h02, 1, 0); b_byte(8'h03, 1, 0); b_stop();
    reg_expect(3'd0, 8'h07, "R4 slave oversize");
    clear_all();

    // R5: early termination by stop
    reg_write(3'd3, 8'd3);
    b_start(); b_byte(8'h74, 1, 0); b_byte(8'h01, 1, 0); b_stop();
    reg_expect(3'd0, 8'h0B, "R5 early by stop");
    clear_all();

    // R5 R3: early termination by repeated start to another address
    b_start(); b_byte(8'h74, 1, 0); b_byte(8'h01, 1, 0);
    b_start(); b_byte(8'hA0, 1, 0); b_byte(8'h02, 1, 0); b_stop();
    reg_expect(3'd0, 8'h09, "R5 early by repeated start, R3 no slave stop");
    clear_all();

    // R10: count restarts at repeated start
    reg_write(3'd3, 8'd2);
    b_start(); b_byte(8'h74, 1, 0); b_byte(8'h01, 1, 0);
    b_start(); b_byte(8'h74, 1, 0); b_byte(8'h02, 1, 0); b_byte(8'h03, 1, 0); b_stop();
    reg_expect(3'd0, 8'h0B, "R10 count reset at repeated start");
    clear_all();

    // R4: master never flags oversize
    mst_active = 1'b1;
    reg_write(3'd3, 8'd1);
    b_start(); b_byte(8'hA0, 1, 1);
    b_byte(8'h01, 1, 1); b_byte(8'h02, 1, 1); b_byte(8'h03, 1, 1); b_stop();
    reg_expect(3'd0, 8'h00, "R4 master no oversize");

    // R5: master early
    reg_write(3'd3, 8'd2);
    b_start(); b_byte(8'hA0, 1, 1); b_byte(8'h01, 1, 1); b_stop();
    reg_expect(3'd0, 8'h08, "R5 master early");
    clear_all();

    // R7: master address not acknowledged
    reg_write(3'd3, 8'd4);
    n0 = nack_cnt;
    b_start(); b_byte(8'hA0, 0, 1);
    check("R7 nack stop request pulses", 8'(nack_cnt - n0), 8'd1);
    b_byte(8'h01, 1, 1); b_byte(8'h02, 1, 1); b_stop();
    reg_expect(3'd0, 8'h20, "R7 nack flag only");
    clear_all();

    // R6: arbitration loss on first address bit
    reg_write(3'd3, 8'd1);
    b_start();
    mst_tx = 1'b1; b_bit(1'b0, 1'b1);
    mst_tx = 1'b0;
    check("R6 arb_lost asserted", {7'b0, arb_lost}, 8'h01);
    for (int i = 0; i < 8; i++) b_bit(1'b0, 1'b0);
    check("R6 arb_lost held", {7'b0, arb_lost}, 8'h01);
    b_stop();
    check("R6 arb_lost released at stop", {7'b0, arb_lost}, 8'h00);
    reg_expect(3'd0, 8'h10, "R6 master loss flag");
    clear_all();

    // R6: master receive with low line is not a loss
    b_start(); b_byte(8'hA0, 1, 1);
    mst_tx = 1'b0;
    for (int i = 0; i < 8; i++) b_bit(1'b0, 1'b1);
    b_bit(1'b0, 1'b1);
    check("R6 no loss on receive", {7'b0, arb_lost}, 8'h00);
    b_stop();
    reg_expect(3'd0, 8'h00, "R6 receive no flags");
    mst_active = 1'b0;

    // R8 R9: mask and clear
    reg_write(3'd3, 8'd1);
    b_start(); b_byte(8'h74, 1, 0); b_byte(8'h01, 1, 0); b_stop();
    tick(3);
    check("R8 irq masked", {7'b0, irq}, 8'h00);
    reg_write(3'd1, 8'h02);
    tick(3);
    check("R8 irq enabled stop flag", {7'b0, irq}, 8'h01);
    reg_expect(3'd0, 8'h03, "R8 mask leaves flags");
    reg_write(3'd0, 8'h02);
    tick(3);
    reg_expect(3'd0, 8'h01, "R9 clear one bit only");
    check("R9 irq drops after clear", {7'b0, irq}, 8'h00);
    reg_write(3'd1, 8'h01);
    tick(3);
    check("R8 irq enabled address flag", {7'b0, irq}, 8'h01);
    reg_write(3'd0, 8'h00);
    tick(3);
    reg_expect(3'd0, 8'h01, "R9 write of zero keeps flags");
    clear_all();
    tick(3);
    check("R9 irq low after full clear", {7'b0, irq}, 8'h00);
    reg_expect(3'd0, 8'h00, "R9 all cleared");

    tick(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule